// File: doc/BRIEF.md
# Weighted Round-Robin Port Arbiter

This block gives one shared output port to one of several requesters. At any moment it grants at most one of them. When the port is free, the choice rotates. The next owner is the lowest-numbered requester above the one granted last. If none of those is waiting, the search wraps to the lowest-numbered requester overall. Once a requester wins, the port stays with it for the whole packet, until the cycle in which the release (last-flit) input is high.

Each requester has a programmable weight. A requester that keeps asking may finish that many packets in a row before the arbiter moves on to a rival. If it drops its request early, the port moves on in the same cycle, and its quota starts again the next time it wins. A packet whose last flit goes out in the very cycle it was granted counts as one completed packet. The grant is combinational from the current request vector, so a switch allocator can use it in the same cycle.

Top module: `wrr_port_arbiter`

## Requirements
- R1: `grant` is one-hot or all-zero, and it never has a bit set whose `req` bit is low.
- R2: `grantValid` is high in exactly the cycles in which at least one `req` bit is high, in the same cycle.
- R3: When no packet is held, the winner is the lowest-index requester above the index of the last fresh grant. Out of reset, the search covers all indexes, so the lowest index wins.
- R4: If no requester above the last fresh grant is waiting, the lowest-index active requester wins (wrap-around).
- R5: A granted requester keeps the grant in every following cycle while its request stays high, until a cycle in which `lastFlit` is high.
- R6: Requester i's weight is `weights[3*i+2:3*i]`. While it keeps requesting, it wins that many packets in a row. After the last of them completes, rival requesters are chosen by R3 and R4. A requester that is alone is granted again.
- R7: A weight field of 0 behaves as a weight of 1.
- R8: If the holder drops its request, the grant moves to another active requester in the same cycle. The holder's packet count restarts when it is next granted.
- R9: A `lastFlit` in the first cycle of a grant counts as one completed packet.
- R10: `lastFlit` in a cycle with no grant has no effect on later grants.
- R11: Out of reset, no packet is held and `grant` is zero while `req` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 5 | One request bit per requester |
| weights | input | 15 | Packed 3-bit packet quota per requester, requester i in bits 3*i+2:3*i |
| lastFlit | input | 1 | High in the cycle the granted packet's last flit is sent |
| grant | output | 5 | One-hot grant vector |
| grantValid | output | 1 | High when some requester is granted |

## Verification
The assertions check the grant-vector invariants on every cycle: at most one bit set, no grant without a request, and the valid flag tracking the requests. They also check that a grant does not move while its packet is open and its request stays high. Only the bench scenarios can show the ordering and the quota: the rotation above the last winner and the wrap-around, the number of back-to-back packets for each weight from 0 to 7, the count starting at one for single-flit packets, and the hand-over when the holder withdraws. A long stretch of mixed traffic is compared cycle by cycle against an arithmetic model of the requirements.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;
  // control -> datapath
  typedef struct packed {
    logic selHeld;  // keep current owner this cycle
    logic take;     // fresh grant: load owner and mask
    logic bump;     // packet done, quota not yet used up
    logic clear;    // no grant or quota used up: zero the count
  } arbStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic ownerReq;  // registered owner still requesting
    logic anyReq;    // some request present
    logic quotaEnd;  // granted requester completes its last allowed packet if lastFlit
  } arbStatus_t;
endpackage

// File: rtl/wrr_arb_datapath.sv
module wrr_arb_datapath
  import wrr_arb_pkg::*;
#(
  parameter int NumReq  = 5,
  parameter int WeightW = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumReq-1:0]         req,
  input  logic [NumReq*WeightW-1:0] weights,
  input  arbStrobe_t                strobe,
  output arbStatus_t                status,
  output logic [NumReq-1:0]         grantVec
);
  localparam int IdxW = (NumReq > 1) ? $clog2(NumReq) : 1;

  logic [IdxW-1:0]    ownerQ, pickIdx, grantIdx;
  logic [NumReq-1:0]  maskQ, maskedReq, nextMask;
  logic [WeightW-1:0] countQ, countBase;
  logic [WeightW-1:0] effW [NumReq];

  function automatic logic [IdxW-1:0] lowestSet(input logic [NumReq-1:0] vec);
    logic [IdxW-1:0] idx;
    idx = '0;
    for (int i = NumReq - 1; i >= 0; i--) begin
      if (vec[i]) idx = IdxW'(i);
    end
    return idx;
  endfunction

  // zero weight is promoted to one
  for (genvar g = 0; g < NumReq; g++) begin : gWeight
    logic [WeightW-1:0] field;
    assign field   = weights[g*WeightW +: WeightW];
    assign effW[g] = (field == '0) ? WeightW'(1) : field;
  end

  assign maskedReq = req & maskQ;
  assign pickIdx   = (|maskedReq) ? lowestSet(maskedReq) : lowestSet(req);
  assign grantIdx  = strobe.selHeld ? ownerQ : pickIdx;
  assign countBase = strobe.take ? '0 : countQ;

  for (genvar g = 0; g < NumReq; g++) begin : gVec
    assign nextMask[g] = (IdxW'(g) > pickIdx);
    assign grantVec[g] = status.anyReq && (grantIdx == IdxW'(g));
  end

  assign status.anyReq   = |req;
  assign status.ownerReq = req[ownerQ];
  assign status.quotaEnd = ({1'b0, countBase} + 1'b1) >= {1'b0, effW[grantIdx]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerQ <= '0;
      maskQ  <= '1;
    end else if (strobe.take) begin
      ownerQ <= pickIdx;
      maskQ  <= nextMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            countQ <= '0;
    else if (strobe.clear) countQ <= '0;
    else if (strobe.bump)  countQ <= countBase + WeightW'(1);
    else if (strobe.take)  countQ <= '0;
  end
endmodule

// File: rtl/wrr_arb_control.sv
module wrr_arb_control
  import wrr_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lastFlit,
  input  arbStatus_t status,
  output arbStrobe_t strobe,
  output logic       grantValid
);
  logic holdingQ, packetDone, quotaDone;

  assign grantValid = status.anyReq;
  assign packetDone = grantValid && lastFlit;
  assign quotaDone  = packetDone && status.quotaEnd;

  assign strobe.selHeld = holdingQ && status.ownerReq;
  assign strobe.take    = grantValid && !strobe.selHeld;
  assign strobe.bump    = packetDone && !status.quotaEnd;
  assign strobe.clear   = !grantValid || quotaDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdingQ <= 1'b0;
    else       holdingQ <= grantValid && !quotaDone;
  end
endmodule

// File: rtl/wrr_port_arbiter.sv
module wrr_port_arbiter
  import wrr_arb_pkg::*;
#(
  parameter int NumReq  = 5,
  parameter int WeightW = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NumReq-1:0]         req,
  input  logic [NumReq*WeightW-1:0] weights,
  input  logic                      lastFlit,
  output logic [NumReq-1:0]         grant,
  output logic                      grantValid
);
  arbStrobe_t strobe;
  arbStatus_t status;

  wrr_arb_control uCtrl (
    .clk(clk), .rstN(rstN), .lastFlit(lastFlit),
    .status(status), .strobe(strobe), .grantValid(grantValid)
  );

  wrr_arb_datapath #(.NumReq(NumReq), .WeightW(WeightW)) uPath (
    .clk(clk), .rstN(rstN), .req(req), .weights(weights),
    .strobe(strobe), .status(status), .grantVec(grant)
  );
endmodule

// File: rtl/wrr_port_arbiter_chk.sv
module wrr_port_arbiter_chk #(
  parameter int NumReq  = 5,
  parameter int WeightW = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NumReq-1:0]         req,
  input logic [NumReq*WeightW-1:0] weights,
  input logic                      lastFlit,
  input logic [NumReq-1:0]         grant,
  input logic                      grantValid
);
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(grant));
  a_r1_only_requested: assert property (@(posedge clk) disable iff (!rstN) (grant & ~req) == '0);
  a_r2_valid_tracks_req: assert property (@(posedge clk) disable iff (!rstN) grantValid == (|req));
  a_r5_hold_open_packet: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && grantValid && !lastFlit) |=>
      (((req & $past(grant)) == '0) || (grant == $past(grant))));
endmodule

bind wrr_port_arbiter wrr_port_arbiter_chk #(.NumReq(NumReq), .WeightW(WeightW)) chk (.*);

// File: tb/tb_wrr_port_arbiter.sv
module tb_wrr_port_arbiter;
  localparam int N = 5;
  localparam int WW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] req = '0;
  logic [N*WW-1:0] weights = '0;
  logic lastFlit = 1'b0;
  logic [N-1:0] grant;
  logic grantValid;

  int total = 0;
  int bad = 0;

  // reference state
  int mOwner, mPrev, mCnt;
  bit mHeld;

  wrr_port_arbiter #(.NumReq(N), .WeightW(WW)) dut (
    .clk(clk), .rstN(rstN), .req(req), .weights(weights),
    .lastFlit(lastFlit), .grant(grant), .grantValid(grantValid)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic setW(input int i, input int w);
    weights[i*WW +: WW] = WW'(w);
  endtask

  function automatic int effW(input int i);
    int w;
    w = int'(weights[i*WW +: WW]);
    return (w == 0) ? 1 : w;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; req = '0; lastFlit = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mOwner = 0; mPrev = -1; mCnt = 0; mHeld = 0;
  endtask

  // drive at negedge, settle, leave sampling to caller before next posedge
  task automatic step(input logic [N-1:0] r, input logic l);
    @(negedge clk);
    req = r; lastFlit = l;
    #5;
  endtask

  function automatic int modelPick();
    if (mHeld && req[mOwner]) return mOwner;
    if (req == '0) return -1;
    for (int i = mPrev + 1; i < N; i++) if (req[i]) return i;
    for (int i = 0; i < N; i++) if (req[i]) return i;
    return -1;
  endfunction

  task automatic modelAdvance(input int idx);
    if (idx < 0) begin
      mHeld = 0; mCnt = 0;
    end else begin
      if (!(mHeld && req[mOwner])) begin
        mOwner = idx; mPrev = idx; mCnt = 0;
      end
      mHeld = 1;
      if (lastFlit) begin
        mCnt++;
        if (mCnt >= effW(idx)) begin mHeld = 0; mCnt = 0; end
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) setW(i, 1);
    doReset();
    // R11 / R2: idle after reset
    step('0, 1'b0);
    chk("R11 idle grant", grant, '0);
    chk("R2 idle valid", {4'b0, grantValid}, '0);
    step(5'b11111, 1'b0);
    chk("R11 R3 first winner", grant, 5'b00001);
    chk("R2 valid", {4'b0, grantValid}, 5'b00001);

    // R6 R7 R9: weight sweep, single-flit packets, rival requester 1
    for (int w = 0; w < 8; w++) begin
      int run;
      bit open;
      setW(0, w); setW(1, 7);
      doReset();
      run = 0; open = 1;
      for (int k = 0; k < 10; k++) begin
        step(5'b00011, 1'b1);
        if (open && grant == 5'b00001) run++;
        else open = 0;
      end
      chk($sformatf("R6 R7 R9 run for weight %0d", w), N'(run), N'((w == 0) ? 1 : w));
    end

    // R5 hold, then R3 rotation and R4 wrap
    for (int i = 0; i < N; i++) setW(i, 1);
    doReset();
    for (int k = 0; k < 5; k++) begin
      step(5'b01011, 1'b0);
      chk("R5 hold open packet", grant, 5'b00001);
    end
    step(5'b01011, 1'b1);
    chk("R5 last cycle", grant, 5'b00001);
    step(5'b01011, 1'b1);
    chk("R3 next above 0", grant, 5'b00010);
    step(5'b01011, 1'b1);
    chk("R3 next above 1", grant, 5'b01000);
    step(5'b01011, 1'b0);
    chk("R4 wrap to lowest", grant, 5'b00001);

    // R8 withdrawal
    for (int i = 0; i < N; i++) setW(i, 7);
    doReset();
    step(5'b00011, 1'b0);
    chk("R8 start", grant, 5'b00001);
    step(5'b00010, 1'b0);
    chk("R8 same-cycle move", grant, 5'b00010);
    step(5'b00011, 1'b0);
    chk("R8 R5 new holder kept", grant, 5'b00010);

    // R10: release pulses with no grant
    setW(0, 2); setW(1, 7);
    doReset();
    for (int k = 0; k < 3; k++) begin
      step('0, 1'b1);
      chk("R10 no grant", grant, '0);
    end
    step(5'b00011, 1'b1);
    chk("R10 quota intact 1", grant, 5'b00001);
    step(5'b00011, 1'b1);
    chk("R10 quota intact 2", grant, 5'b00001);
    step(5'b00011, 1'b1);
    chk("R10 R6 yield", grant, 5'b00010);

    // mixed traffic against the reference
    for (int blk = 0; blk < 6; blk++) begin
      for (int i = 0; i < N; i++) setW(i, int'($urandom % 8));
      doReset();
      for (int c = 0; c < 600; c++) begin
        int idx;
        logic [N-1:0] expG;
        step(N'($urandom), (($urandom % 3) == 0));
        idx = modelPick();
        expG = (idx < 0) ? '0 : (N'(1) << idx);
        chk("R3 R4 R6 R8 model grant", grant, expG);
        chk("R2 model valid", {4'b0, grantValid}, {4'b0, (idx >= 0)});
        modelAdvance(idx);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule